// File: doc/BRIEF.md
# Jumping Sequence Counter

This block is a 4-bit synchronous counter that steps through the fixed cycle 2, 3, 5, 6, 7, 10, 11, 15, 1 and then returns to 2. It is built from a plain modulo-16 counter core. The core has clear, parallel load and count enable. Small combinational jump logic sits beside the core. When the state has both low bits set and counting is enabled, the jump logic raises the core's load strobe and presents the next value of the cycle. Every other step is an ordinary increment.

The user drives a count enable and a synchronous clear. The outputs are the current state and a terminal-count flag. An active-low asynchronous reset brings the state to 0. After a clear the state is also 0. From 0 the counter increments to 1 and then joins the cycle. States that are not part of the cycle use the same minimized logic, so they drift back into the cycle within a few enabled clocks.

Top module: `seqcnt_top`

## Requirements
- R1: While rst_ni is low, q_o is 0 (0000b), independent of the clock.
- R2: A clock edge with clr_i high sets q_o to 0. This takes priority over en_i.
- R3: A clock edge with clr_i low and en_i low leaves q_o unchanged.
- R4: tc_o is 1 exactly when q_o is 15 and en_i is 1. Otherwise tc_o is 0.
- R5: With en_i held high, q_o visits 2, 3, 5, 6, 7, 10, 11, 15, 1 in that order and then returns to 2.
- R6: On an enabled edge, the states whose two low bits are both 1 jump: 3 goes to 5, 7 goes to 10, 11 goes to 15 and 15 goes to 1. All other in-cycle steps add one.
- R7: After a clear, the first enabled edge gives 1 and the second gives 2.
- R8: The off-cycle states 0, 4, 8, 9, 12, 13 and 14 each add one on an enabled edge. Each of them reaches a cycle state within at most 3 enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to 0 |
| en_i | input | 1 | Count enable |
| q_o | output | 4 | Current counter state |
| tc_o | output | 1 | Terminal count: state 15 with enable high |

## Verification
The off-cycle states 4, 8, 9, 12, 13 and 14 can never be reached from the top ports. Reset and clear only produce 0, and the cycle never leaves its nine states. To reach them, the bench builds a second copy from the same core and jump-logic modules. It adds a preload path ahead of the core's load input, seeds each off-cycle state, and then hands the load control back to the jump logic. It then checks that each enabled step adds one and that a cycle state is reached within three steps. The main instance runs long random runs of enable and rare clears against a sequence model.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/seqcnt_core.sv
module seqcnt_core #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         tc_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] q_q, q_d;

  // priority: clear, load, count, hold
  always_comb begin
    if (clr_i)     q_d = '0;
    else if (ld_i) q_d = d_i;
    else if (en_i) q_d = q_q + 1'b1;
    else           q_d = q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o  = q_q;
  assign tc_o = en_i && (q_q == TOP);
endmodule

// File: rtl/seqcnt_jump.sv
module seqcnt_jump
  import seqcnt_pkg::*;
(
  input  cnt_t q_i,
  input  logic en_i,
  output logic ld_o,
  output cnt_t d_o
);
  logic x32;

  // minimized from the cycle table; only meaningful where q[1:0] == 11
  assign x32    = q_i[3] ^ q_i[2];
  assign ld_o   = q_i[1] & q_i[0] & en_i;
  assign d_o[3] = x32;
  assign d_o[2] = ~q_i[2];
  assign d_o[1] = x32;
  assign d_o[0] = q_i[3] | ~q_i[2];
endmodule

// File: rtl/seqcnt_top.sv
module seqcnt_top
  import seqcnt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  output logic [3:0] q_o,
  output logic       tc_o
);
  cnt_t q, jd;
  logic jl;

  seqcnt_jump u_jump (
    .q_i (q),
    .en_i(en_i),
    .ld_o(jl),
    .d_o (jd)
  );

  seqcnt_core #(.W(CNT_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .ld_i  (jl),
    .en_i  (en_i),
    .d_i   (jd),
    .q_o   (q),
    .tc_o  (tc_o)
  );

  assign q_o = q;
endmodule

// File: rtl/seqcnt_checker.sv
module seqcnt_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       en_i,
  input logic [3:0] q_o,
  input logic       tc_o
);
  function automatic logic in_cyc(input logic [3:0] v);
    case (v)
      4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11, 4'd15: in_cyc = 1'b1;
      default: in_cyc = 1'b0;
    endcase
  endfunction

  always_comb begin
    if (!rst_ni) assert_reset_zero_R1: assert (q_o == 4'd0);
  end

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_o == 4'd0);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(q_o));
  assert_tc_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !clr_i) |=> q_o == 4'd1);
  assert_stay_in_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cyc(q_o) && en_i && !clr_i) |=> in_cyc(q_o));
  assert_jump3_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == 4'd3 && en_i && !clr_i) |=> q_o == 4'd5);
  assert_jump7_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == 4'd7 && en_i && !clr_i) |=> q_o == 4'd10);
  assert_jump11_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == 4'd11 && en_i && !clr_i) |=> q_o == 4'd15);
  assert_from_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == 4'd0 && en_i && !clr_i) |=> q_o == 4'd1);
endmodule

bind seqcnt_top seqcnt_checker u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .clr_i (clr_i),
  .en_i  (en_i),
  .q_o   (q_o),
  .tc_o  (tc_o)
);

// File: tb/seqcnt_top_bench.sv
module seqcnt_top_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic en = 1'b0;
  logic [3:0] q;
  logic tc;

  // auxiliary copy with a preload path, for off-cycle states
  logic pre = 1'b0;
  logic [3:0] pre_v = 4'd0;
  logic aen = 1'b0;
  logic [3:0] aq, ajd;
  logic ajl, atc;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqcnt_top u_seqcnt_top (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en), .q_o(q), .tc_o(tc)
  );

  seqcnt_jump u_aux_jump (.q_i(aq), .en_i(aen), .ld_o(ajl), .d_o(ajd));
  seqcnt_core #(.W(4)) u_aux_core (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(1'b0),
    .ld_i(pre ? 1'b1 : ajl), .en_i(aen), .d_i(pre ? pre_v : ajd),
    .q_o(aq), .tc_o(atc)
  );

  function automatic logic [3:0] succ(input logic [3:0] s);
    case (s)
      4'd3:    succ = 4'd5;
      4'd7:    succ = 4'd10;
      4'd11:   succ = 4'd15;
      4'd15:   succ = 4'd1;
      default: succ = s + 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] model(input logic [3:0] s, input logic c, input logic e);
    if (c)      model = 4'd0;
    else if (e) model = succ(s);
    else        model = s;
  endfunction

  function automatic logic cyc_state(input logic [3:0] v);
    case (v)
      4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11, 4'd15: cyc_state = 1'b1;
      default: cyc_state = 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // called just after a negedge; samples at the next negedge
  task automatic step(input logic c, input logic e, input string req);
    clr = c;
    en = e;
    #1;
    chk("R4 tc", int'(tc), int'(exp_q == 4'd15 && e));
    exp_q = model(exp_q, c, e);
    @(negedge clk);
    chk(req, int'(q), int'(exp_q));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] order [9];
    void'($urandom(32'h5EC0_17A5));
    order = '{4'd2, 4'd3, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11, 4'd15, 4'd1};

    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 reset", int'(q), 0);
    en = 1'b1;
    @(negedge clk);
    chk("R1 reset held", int'(q), 0);
    en = 1'b0;
    rst_n = 1'b1;
    exp_q = 4'd0;

    // R7 clear then 1, then 2
    step(1'b0, 1'b1, "R7 first step");
    step(1'b0, 1'b1, "R7 second step");

    // R5/R6 three full loops in order
    for (int lp = 0; lp < 3; lp++) begin
      for (int i = 1; i < 10; i++) begin
        step(1'b0, 1'b1, "R6 step");
        chk("R5 order", int'(q), int'(order[i % 9]));
      end
    end

    // R3 hold at a jump state, R4 tc low with enable low
    while (exp_q != 4'd15) step(1'b0, 1'b1, "R5 walk");
    step(1'b0, 1'b0, "R3 hold at 15");
    step(1'b0, 1'b1, "R6 15 to 1");

    // R2 clear beats enable
    step(1'b1, 1'b1, "R2 clear with enable");
    step(1'b0, 1'b0, "R3 hold at 0");

    // random enable stretches, rare clears
    for (int n = 0; n < 400; n++) begin
      logic c, e;
      c = ($urandom_range(0, 49) == 0);
      e = ($urandom_range(0, 9) < 6);
      step(c, e, c ? "R2 random clear" : (e ? "R6 random step" : "R3 random hold"));
    end
    clr = 1'b0;
    en = 1'b0;

    // R8 off-cycle states via aux copy
    foreach (order[k]) begin end
    for (int k = 0; k < 7; k++) begin
      logic [3:0] s, e8;
      int steps;
      case (k)
        0: s = 4'd0; 1: s = 4'd4; 2: s = 4'd8; 3: s = 4'd9;
        4: s = 4'd12; 5: s = 4'd13; default: s = 4'd14;
      endcase
      pre = 1'b1;
      pre_v = s;
      aen = 1'b0;
      @(negedge clk);
      pre = 1'b0;
      chk("R8 preload", int'(aq), int'(s));
      e8 = s;
      steps = 0;
      while (!cyc_state(e8) && steps < 4) begin
        aen = 1'b1;
        e8 = e8 + 4'd1;
        steps++;
        @(negedge clk);
        chk("R8 off-cycle increment", int'(aq), int'(e8));
      end
      aen = 1'b0;
      chk("R8 reached cycle within 3", int'(cyc_state(aq) && steps <= 3), 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule